// File: doc/BRIEF.md
# Sampling-Converter Serial Port Slave

This block is the digital side of the serial port of a converter that takes sixteen serial clocks per sample. It is a slave. A host drives an active-low select, a serial clock and a data line into the block. The block sends back a 16-bit frame and receives a 16-bit write word at the same time. The analog conversion is not modelled. A parallel result input stands in for it, made of a channel tag, a sign bit and a 12-bit magnitude. The block captures that input when select falls and shifts it out MSB first. While it does so, a track/hold output stays in hold.

The incoming word starts with a write flag and a 2-bit register selector. The data bits follow. The 12-bit control register commits its data on the 15th rising serial clock edge. The sequence register and the two range registers hold 8 bits each and commit on the 11th falling edge. The serial data output comes as a data bit plus two enables, strong and weak. When bit 0 of the control register is set, the idle line is held weakly at the MSB of the channel tag for the next frame.

All serial inputs are treated as levels sampled by a faster system clock `clk`. Each output reacts one `clk` cycle after the input edge that triggers it.

Top module: `adc_serial_port`

## Requirements
- R1: One cycle after select falls, `dout_oe` is 1, `track` is 0 (hold) and `dout` shows bit 15 of the frame {chan[2:0], sign, mag[11:0]}.
- R2: Frame bits are taken from the result inputs at select fall. Each serial clock falling edge k (1 to 15) moves `dout` to frame bit 15-k. Later changes on the result inputs do not alter the frame.
- R3: `track` stays 0 until the 14th rising serial clock edge of the frame and becomes 1 after it.
- R4: After the 16th falling edge, `dout_oe` is 0.
- R5: When select is high, `dout_oe` is 0 and `track` is 1 on the next cycle. This applies to an aborted frame as well.
- R6: Write word bit 1 (first received) is the write flag. Bits 2 and 3 are the selector: 00 selects control, 01 selects range A, 10 selects range B and 11 selects sequence.
- R7: For a control write, bits 4 to 15 load `ctrl_q[11:0]` (bit 4 lands in the MSB) at the 15th rising edge.
- R8: For a sequence or range write, bits 4 to 11 load the selected 8-bit register (bit 4 lands in the MSB) at the 11th falling edge.
- R9: A register is left unchanged when the write flag is 0, or when select rises before that register's commit edge.
- R10: When idle with `ctrl_q[0]`=1, `dout_weak` is 1 and `dout` equals the live `res_chan[2]`. With `ctrl_q[0]`=0, `dout_weak` is 0.
- R11: `dout_oe` and `dout_weak` are never 1 together.
- R12: After reset, all registers are 0, `dout_oe` and `dout_weak` are 0 and `track` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock level, high when idle |
| din | input | 1 | Serial write data |
| res_chan | input | 3 | Channel tag of the result |
| res_sign | input | 1 | Sign of the result |
| res_mag | input | 12 | Result magnitude |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Strong drive enable |
| dout_weak | output | 1 | Weak drive enable (idle only) |
| track | output | 1 | 1 = track, 0 = hold |
| ctrl_q | output | 12 | Control register, bit 0 selects weak idle drive |
| seq_q | output | 8 | Sequence register |
| range_a_q | output | 8 | Range register A |
| range_b_q | output | 8 | Range register B |

## Verification
The assertions assume that `cs_n`, `sclk` and `din` are already synchronous to `clk`. They also assume that each serial clock level lasts several `clk` cycles and that select changes only while `sclk` is high, so a select edge never lands on the same cycle as a serial clock edge. The stimulus meets these assumptions:
- every input changes on the falling edge of `clk`;
- each serial phase is held for three cycles;
- select moves only between serial cycles.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL    = 2'b00,
    SEL_RANGE_A = 2'b01,
    SEL_RANGE_B = 2'b10,
    SEL_SEQ     = 2'b11
  } reg_sel_e;
endpackage

// File: rtl/sp_edge_det.sv
module sp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  output logic sclk_fall,
  output logic sclk_rise,
  output logic cs_fall
);
  logic sclk_q, cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  assign sclk_fall = sclk_q & ~sclk;
  assign sclk_rise = ~sclk_q & sclk;
  assign cs_fall   = cs_q & ~cs_n;
endmodule

// File: rtl/sp_frame_ctl.sv
module sp_frame_ctl #(
  parameter int FRAME      = 16,
  parameter int TRACK_EDGE = 14,
  parameter int CNT_W      = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             cs_fall,
  input  logic             sclk_fall,
  input  logic             sclk_rise,
  output logic             active,
  output logic             track,
  output logic             fall_stb,
  output logic             rise_stb,
  output logic [CNT_W-1:0] fall_num,
  output logic [CNT_W-1:0] rise_num
);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(FRAME);
  localparam logic [CNT_W-1:0] TRK_RISE  = CNT_W'(TRACK_EDGE);

  logic [CNT_W-1:0] fcnt_q, fcnt_d, rcnt_q, rcnt_d;
  logic             active_d, track_d;

  assign fall_stb = active & ~cs_n & ~cs_fall & sclk_fall;
  assign rise_stb = active & ~cs_n & ~cs_fall & sclk_rise;
  assign fall_num = fcnt_q + CNT_W'(1);
  assign rise_num = rcnt_q + CNT_W'(1);

  always_comb begin
    active_d = active;
    track_d  = track;
    fcnt_d   = fcnt_q;
    rcnt_d   = rcnt_q;
    if (cs_fall) begin
      active_d = 1'b1;
      track_d  = 1'b0;
      fcnt_d   = '0;
      rcnt_d   = '0;
    end else if (cs_n) begin
      active_d = 1'b0;
      track_d  = 1'b1;
    end else begin
      if (fall_stb) begin
        fcnt_d = fall_num;
        if (fall_num == LAST_FALL) active_d = 1'b0;
      end
      if (rise_stb) begin
        rcnt_d = rise_num;
        if (rise_num == TRK_RISE) track_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      track  <= 1'b1;
      fcnt_q <= '0;
      rcnt_q <= '0;
    end else begin
      active <= active_d;
      track  <= track_d;
      fcnt_q <= fcnt_d;
      rcnt_q <= rcnt_d;
    end
  end
endmodule

// File: rtl/sp_tx_path.sv
module sp_tx_path #(
  parameter int FRAME = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [FRAME-1:0] frame_in,
  input  logic             active,
  input  logic             weak_mode,
  input  logic             next_msb,
  output logic             dout,
  output logic             dout_oe,
  output logic             dout_weak
);
  logic [FRAME-1:0] sr_q, sr_d;

  always_comb begin
    sr_d = sr_q;
    if (load)       sr_d = frame_in;
    else if (shift) sr_d = {sr_q[FRAME-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign dout_oe   = active;
  assign dout_weak = ~active & weak_mode;
  assign dout      = active ? sr_q[FRAME-1] : (weak_mode & next_msb);
endmodule

// File: rtl/sp_rx_regs.sv
module sp_rx_regs
  import adc_sp_pkg::*;
#(
  parameter int CTRL_W = 12,
  parameter int AUX_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              fall_stb,
  input  logic              rise_stb,
  input  logic [CNT_W-1:0]  fall_num,
  input  logic [CNT_W-1:0]  rise_num,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [AUX_W-1:0]  seq_q,
  output logic [AUX_W-1:0]  range_a_q,
  output logic [AUX_W-1:0]  range_b_q
);
  localparam int CTRL_COMMIT = 3 + CTRL_W;
  localparam int AUX_COMMIT  = 3 + AUX_W;
  localparam int SR_W        = CTRL_COMMIT;

  logic [SR_W-1:0]       sr_q, sr_d;
  logic [AUX_COMMIT-1:0] aux_word;
  logic [1:0]            aux_sel;
  logic                  aux_go, ctrl_go;
  logic [CTRL_W-1:0]     ctrl_d;

  // word seen at the aux commit edge: earlier bits plus the bit arriving now
  assign aux_word = {sr_q[AUX_COMMIT-2:0], din};
  assign aux_sel  = aux_word[AUX_COMMIT-2 -: 2];
  assign aux_go   = fall_stb && (fall_num == CNT_W'(AUX_COMMIT))
                    && aux_word[AUX_COMMIT-1]
                    && (reg_sel_e'(aux_sel) != SEL_CTRL);
  assign ctrl_go  = rise_stb && (rise_num == CNT_W'(CTRL_COMMIT))
                    && sr_q[SR_W-1]
                    && (reg_sel_e'(sr_q[SR_W-2 -: 2]) == SEL_CTRL);

  always_comb begin
    sr_d   = fall_stb ? {sr_q[SR_W-2:0], din} : sr_q;
    ctrl_d = ctrl_go ? sr_q[CTRL_W-1:0] : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      ctrl_q <= '0;
    end else begin
      sr_q   <= sr_d;
      ctrl_q <= ctrl_d;
    end
  end

  for (genvar g = 1; g < 4; g++) begin : g_aux
    logic [AUX_W-1:0] q;
    logic             en;
    assign en = aux_go && (aux_sel == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= aux_word[AUX_W-1:0];
    end
  end

  assign range_a_q = g_aux[1].q;
  assign range_b_q = g_aux[2].q;
  assign seq_q     = g_aux[3].q;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int CHAN_W   = 3,
  parameter int MAG_W    = 12,
  parameter int CTRL_W   = 12,
  parameter int AUX_W    = 8,
  parameter int WEAK_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_sign,
  input  logic [MAG_W-1:0]  res_mag,
  output logic              dout,
  output logic              dout_oe,
  output logic              dout_weak,
  output logic              track,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [AUX_W-1:0]  seq_q,
  output logic [AUX_W-1:0]  range_a_q,
  output logic [AUX_W-1:0]  range_b_q
);
  localparam int FRAME      = CHAN_W + 1 + MAG_W;
  localparam int CNT_W      = $clog2(FRAME + 1);
  localparam int TRACK_EDGE = FRAME - 2;

  // reset: asserted at once, released on clk through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic             sclk_fall, sclk_rise, cs_fall;
  logic             active, fall_stb, rise_stb;
  logic [CNT_W-1:0] fall_num, rise_num;

  sp_edge_det u_edge (
    .clk(clk), .rst_n(rst_s2), .sclk(sclk), .cs_n(cs_n),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise), .cs_fall(cs_fall)
  );

  sp_frame_ctl #(.FRAME(FRAME), .TRACK_EDGE(TRACK_EDGE), .CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_s2), .cs_n(cs_n), .cs_fall(cs_fall),
    .sclk_fall(sclk_fall), .sclk_rise(sclk_rise),
    .active(active), .track(track), .fall_stb(fall_stb), .rise_stb(rise_stb),
    .fall_num(fall_num), .rise_num(rise_num)
  );

  sp_tx_path #(.FRAME(FRAME)) u_tx (
    .clk(clk), .rst_n(rst_s2), .load(cs_fall), .shift(fall_stb),
    .frame_in({res_chan, res_sign, res_mag}), .active(active),
    .weak_mode(ctrl_q[WEAK_BIT]), .next_msb(res_chan[CHAN_W-1]),
    .dout(dout), .dout_oe(dout_oe), .dout_weak(dout_weak)
  );

  sp_rx_regs #(.CTRL_W(CTRL_W), .AUX_W(AUX_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_s2), .din(din), .fall_stb(fall_stb),
    .rise_stb(rise_stb), .fall_num(fall_num), .rise_num(rise_num),
    .ctrl_q(ctrl_q), .seq_q(seq_q), .range_a_q(range_a_q), .range_b_q(range_b_q)
  );
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int CTRL_W = 12,
  parameter int AUX_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              dout,
  input logic              dout_oe,
  input logic              dout_weak,
  input logic              track,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [AUX_W-1:0]  seq_q,
  input logic [AUX_W-1:0]  range_a_q,
  input logic [AUX_W-1:0]  range_b_q
);
  assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> (dout_oe && !track));

  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!dout_oe && track));

  assert_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dout_oe && dout_weak));

  assert_hold_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> ($stable(ctrl_q) && $stable(seq_q)
                              && $stable(range_a_q) && $stable(range_b_q)));

  assert_shift_only_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe && $past(dout_oe) && ($past(sclk) == $past(sclk, 2))) |-> $stable(dout));
endmodule

bind adc_serial_port sp_checker #(.CTRL_W(CTRL_W), .AUX_W(AUX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .dout(dout),
  .dout_oe(dout_oe), .dout_weak(dout_weak), .track(track), .ctrl_q(ctrl_q),
  .seq_q(seq_q), .range_a_q(range_a_q), .range_b_q(range_b_q)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sclk, din;
  logic [2:0]  res_chan;
  logic        res_sign;
  logic [11:0] res_mag;
  logic        dout, dout_oe, dout_weak, track;
  logic [11:0] ctrl_q;
  logic [7:0]  seq_q, range_a_q, range_b_q;

  int n_tests = 0;
  int n_fail  = 0;
  logic [11:0] e_ctrl;
  logic [7:0]  e_seq, e_ra, e_rb;

  always #(CLK_P/2) clk = ~clk;

  adc_serial_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
    .res_chan(res_chan), .res_sign(res_sign), .res_mag(res_mag),
    .dout(dout), .dout_oe(dout_oe), .dout_weak(dout_weak), .track(track),
    .ctrl_q(ctrl_q), .seq_q(seq_q), .range_a_q(range_a_q), .range_b_q(range_b_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_idle();
    check("R10 weak enable", {31'd0, dout_weak}, {31'd0, e_ctrl[0]});
    check("R11 strong off in idle", {31'd0, dout_oe}, 32'd0);
    if (e_ctrl[0]) check("R10 weak value", {31'd0, dout}, {31'd0, res_chan[2]});
  endtask

  task automatic run_frame(input logic [15:0] win, input int ncyc,
                           input logic [2:0] ch, input logic sg, input logic [11:0] mg);
    logic [15:0] frm;
    frm = {ch, sg, mg};
    res_chan = ch; res_sign = sg; res_mag = mg;
    wait_clk(2);
    cs_n = 1'b0;
    wait_clk(3);
    check("R1 oe", {31'd0, dout_oe}, 32'd1);
    check("R1 hold", {31'd0, track}, 32'd0);
    check("R1 first bit", {31'd0, dout}, {31'd0, frm[15]});
    // inputs move during the frame; the frame must not (R2)
    res_chan = ~ch; res_sign = ~sg; res_mag = ~mg;
    for (int k = 1; k <= ncyc; k++) begin
      sclk = 1'b0;
      din  = win[16-k];
      wait_clk(3);
      if (k < 16) begin
        check("R2 frame bit", {31'd0, dout}, {31'd0, frm[15-k]});
        check("R2 oe in frame", {31'd0, dout_oe}, 32'd1);
      end else begin
        check("R4 release after last fall", {31'd0, dout_oe}, 32'd0);
      end
      sclk = 1'b1;
      wait_clk(3);
      if (k == 13) check("R3 still hold", {31'd0, track}, 32'd0);
      if (k == 14) check("R3 back to track", {31'd0, track}, 32'd1);
    end
    // R6 decode: win[15] write flag, win[14:13] selector
    if (win[15] && ncyc >= 11) begin
      case (win[14:13])
        2'b01: e_ra  = win[12:5];
        2'b10: e_rb  = win[12:5];
        2'b11: e_seq = win[12:5];
        default: ;
      endcase
    end
    if (win[15] && ncyc >= 15 && win[14:13] == 2'b00) e_ctrl = win[12:1];
    cs_n = 1'b1;
    wait_clk(3);
    if (ncyc < 16) check("R5 abort release", {31'd0, dout_oe}, 32'd0);
    check("R5 track after select high", {31'd0, track}, 32'd1);
    check("R7 R9 ctrl", {20'd0, ctrl_q}, {20'd0, e_ctrl});
    check("R8 R9 range A", {24'd0, range_a_q}, {24'd0, e_ra});
    check("R8 R9 range B", {24'd0, range_b_q}, {24'd0, e_rb});
    check("R8 R9 sequence", {24'd0, seq_q}, {24'd0, e_seq});
    check_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int lens [5] = '{16, 10, 11, 14, 15};
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
    res_chan = 3'd0; res_sign = 1'b0; res_mag = 12'd0;
    e_ctrl = '0; e_seq = '0; e_ra = '0; e_rb = '0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(4);
    // R12 reset state
    check("R12 oe", {31'd0, dout_oe}, 32'd0);
    check("R12 weak", {31'd0, dout_weak}, 32'd0);
    check("R12 track", {31'd0, track}, 32'd1);
    check("R12 regs", {ctrl_q, seq_q, range_a_q, range_b_q[7:4]},
                      32'd0);
    check("R12 range B", {24'd0, range_b_q}, 32'd0);

    // sweep write flag x selector x frame length (R6..R9)
    for (int wr = 0; wr < 2; wr++)
      for (int sel = 0; sel < 4; sel++)
        for (int li = 0; li < 5; li++) begin
          logic [12:0] dat;
          dat = 13'((sel * 1234 + li * 777 + wr * 99) ^ 13'h0AAA);
          run_frame({wr[0], sel[1:0], dat}, lens[li],
                    3'(sel + li), 1'((sel + li) % 2), 12'(li * 911 + sel * 307 + 5));
        end

    // weak idle drive on, then both channel MSB values (R10, R11)
    run_frame({1'b1, 2'b00, 12'h5A3, 1'b0}, 16, 3'b101, 1'b1, 12'hF0F);
    check("R10 weak set", {31'd0, dout_weak}, 32'd1);
    res_chan = 3'b100; wait_clk(2);
    check("R10 weak follows 1", {31'd0, dout}, 32'd1);
    res_chan = 3'b011; wait_clk(2);
    check("R10 weak follows 0", {31'd0, dout}, 32'd0);
    // a frame with weak mode on, then write-flag 0 to control (R9)
    run_frame({1'b0, 2'b00, 12'h000, 1'b0}, 16, 3'b010, 1'b0, 12'h123);
    // clear weak mode
    run_frame({1'b1, 2'b00, 12'h800, 1'b0}, 16, 3'b111, 1'b1, 12'hABC);
    check("R10 weak cleared", {31'd0, dout_weak}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule